// File: doc/BRIEF.md
# Two-Wire Bus Target with Clock Stretching

This block is the target side of an I2C (two-wire) serial bus. It watches the clock line and the data line through a synchronizer and finds START and STOP conditions. It takes the byte that follows each START as a 7-bit address plus a direction bit. When that address is one of its own, it acknowledges it. Otherwise it stays silent until the next START. After a matching address, it moves data bytes in either direction, one byte per host handshake.

A local host sees a small set of flags and pulse inputs. Two flags ask the host to act: the address flag and the data flag. While either of them is pending, the block holds the bus clock low. The controller on the bus therefore waits for the host however long it takes, and no byte can be overrun. A direction flag, a bus error flag, a collision flag and a clock-hold indication report the state of the transfer.

The block has two optional address behaviours. A promiscuous input makes every address a match. The general-call byte 0x00 is always accepted.

Top module: `i2c_target_stretch`

## Requirements
- R1: While reset is applied and right after it, all flags are 0, `rx_data` is 0, and neither `scl_oe` nor `sda_oe` drives the bus.
- R2: A START is a falling SDA while SCL is high, and a STOP is a rising SDA while SCL is high. A START at any point, including partway through a data byte, restarts address reception.
- R3: An address byte is received MSB first: seven address bits, then the R/W bit as bit 0. When the 7-bit address equals `own_addr`, the target pulls SDA low during the ninth clock (ACK). After that clock's falling edge, `flag_addr` is set and `dir_rd` equals the R/W bit.
- R4: On an address that does not match, SDA stays released (NACK) and no flag is set. Further bytes on the bus are not acknowledged until the next START.
- R5: While `promisc_en` is 1, every address is acknowledged and handled as a match.
- R6: The general-call byte 0x00 (address 0, R/W = 0) is acknowledged as a write and sets `flag_addr`, whatever the value of `own_addr`.
- R7: A STOP after a START with no completed clock pulse in between sets `bus_err`.
- R8: `scl_oe` and `clk_hold` are 1 whenever `flag_addr` or `flag_data` is set, and return to 0 once the host has cleared both flags with `clr_addr` and `clr_data`.
- R9: In a write transfer, each received byte (MSB first) appears on `rx_data` and is acknowledged by the target. After the ACK clock, `flag_data` is set.
- R10: After an acknowledged read address, `flag_data` is set to request a byte. The `clr_data` pulse loads `tx_data`, which is then sent MSB first. SDA changes only while SCL is low.
- R11: In a read, an ACK from the controller after a byte sets `flag_data` again for the next byte. A NACK makes the target release SDA and set no flag until the next START.
- R12: If the target leaves SDA released for a 1 bit but samples SDA low on that bit's rising clock edge, `collision` is set and the target drives nothing more until the next START.
- R13: A `clr_err` pulse clears both `bus_err` and `collision`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must be much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Sampled level of the bus clock line |
| sda_i | input | 1 | Sampled level of the bus data line |
| scl_oe | output | 1 | 1 pulls the clock line low (open-drain) |
| sda_oe | output | 1 | 1 pulls the data line low (open-drain) |
| own_addr | input | 7 | Address this target answers to |
| promisc_en | input | 1 | Accept every address |
| tx_data | input | 8 | Byte to send, taken when `clr_data` answers a read request |
| clr_addr | input | 1 | Pulse: clear the address flag |
| clr_data | input | 1 | Pulse: clear the data flag |
| clr_err | input | 1 | Pulse: clear bus error and collision |
| rx_data | output | 8 | Last byte received in a write |
| flag_addr | output | 1 | A matching address was acknowledged |
| flag_data | output | 1 | A byte was received, or a byte to send is wanted |
| dir_rd | output | 1 | R/W bit of the last matching address (1 = controller reads) |
| bus_err | output | 1 | START directly followed by STOP |
| collision | output | 1 | Lost arbitration while sending |
| clk_hold | output | 1 | The target is holding the bus clock low |

## Verification
Most internal faults show at the ports within one bus bit time. A wrong bit counter or shift register makes the ACK land on the wrong clock, or corrupts a read byte the controller samples. A wrong match decision flips the ACK level the controller sees on the ninth clock of the address. A flag that is not set or not cleared shows at once: the bus clock is either never held or held forever, so the controller model stalls. A lost direction or error state shows on the host flags right after the edge that should have set it.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_A,
    ST_WR,
    ST_ACK_W,
    ST_RD_WAIT,
    ST_RD,
    ST_RD_ACK,
    ST_IGNORE
  } tgt_state_e;
endpackage

// File: rtl/i2ct_line_sync.sv
module i2ct_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic              scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  always_comb begin
    scl_s     = scl_ff[STAGES-1];
    sda_s     = sda_ff[STAGES-1];
    scl_rise  = scl_s & ~scl_q;
    scl_fall  = ~scl_s & scl_q;
    start_det = scl_s & scl_q & sda_q & ~sda_s;
    stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  end
endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
  import i2ct_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [DATA_W-2:0] own_addr,
  input  logic              promisc_en,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              clr_addr,
  input  logic              clr_data,
  input  logic              clr_err,
  output logic              sda_drv,
  output logic [DATA_W-1:0] rx_data,
  output logic              flag_addr,
  output logic              flag_data,
  output logic              dir_rd,
  output logic              bus_err,
  output logic              collision
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  tgt_state_e        state_q, state_d;
  logic [DATA_W-1:0] sr_q, sr_d, rx_q, rx_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic rose_q, rose_d, drv_q, drv_d, fa_q, fa_d, fd_q, fd_d;
  logic dir_q, dir_d, berr_q, berr_d, coll_q, coll_d;
  logic addr_hit;

  // address match: own address, general call byte, or accept-all
  assign addr_hit = promisc_en | (sr_q[DATA_W-1:1] == own_addr) | (sr_q == '0);

  always_comb begin
    state_d = state_q; sr_d = sr_q; cnt_d = cnt_q; rose_d = rose_q;
    drv_d = drv_q; fa_d = fa_q; fd_d = fd_q; dir_d = dir_q;
    berr_d = berr_q; coll_d = coll_q; rx_d = rx_q;
    if (clr_addr) fa_d = 1'b0;
    if (clr_err) begin
      berr_d = 1'b0;
      coll_d = 1'b0;
    end
    if (clr_data) begin
      fd_d = 1'b0;
      if (state_q == ST_RD_WAIT && fd_q) begin
        sr_d    = tx_data;
        drv_d   = ~tx_data[DATA_W-1];
        cnt_d   = '0;
        rose_d  = 1'b0;
        state_d = ST_RD;
      end
    end
    if (start_det) begin
      state_d = ST_ADDR; cnt_d = '0; rose_d = 1'b0; drv_d = 1'b0;
    end else if (stop_det) begin
      if (state_q == ST_ADDR && cnt_q == '0) berr_d = 1'b1;
      state_d = ST_IDLE; drv_d = 1'b0; rose_d = 1'b0;
    end else if (scl_rise) begin
      rose_d = 1'b1;
      case (state_q)
        ST_ADDR, ST_WR: sr_d = {sr_q[DATA_W-2:0], sda_s};
        ST_RD: if (sr_q[DATA_W-1] && !sda_s) begin
          coll_d = 1'b1; drv_d = 1'b0; state_d = ST_IGNORE;
        end
        ST_RD_ACK: sr_d[0] = sda_s;
        default: ;
      endcase
    end else if (scl_fall && rose_q) begin
      rose_d = 1'b0;
      case (state_q)
        ST_ADDR: begin
          cnt_d = cnt_q + CNT_W'(1);
          if (cnt_q == LAST_BIT) begin
            if (addr_hit) begin
              dir_d = sr_q[0]; drv_d = 1'b1; state_d = ST_ACK_A;
            end else begin
              state_d = ST_IGNORE;
            end
          end
        end
        ST_ACK_A: begin
          drv_d = 1'b0; fa_d = 1'b1; cnt_d = '0;
          if (dir_q) begin
            fd_d = 1'b1; state_d = ST_RD_WAIT;
          end else begin
            state_d = ST_WR;
          end
        end
        ST_WR: begin
          cnt_d = cnt_q + CNT_W'(1);
          if (cnt_q == LAST_BIT) begin
            rx_d = sr_q; drv_d = 1'b1; state_d = ST_ACK_W;
          end
        end
        ST_ACK_W: begin
          drv_d = 1'b0; fd_d = 1'b1; cnt_d = '0; state_d = ST_WR;
        end
        ST_RD: begin
          cnt_d = cnt_q + CNT_W'(1);
          sr_d  = {sr_q[DATA_W-2:0], 1'b0};
          if (cnt_q == LAST_BIT) begin
            drv_d = 1'b0; state_d = ST_RD_ACK;
          end else begin
            drv_d = ~sr_q[DATA_W-2];
          end
        end
        ST_RD_ACK: begin
          if (!sr_q[0]) begin
            fd_d = 1'b1; state_d = ST_RD_WAIT;
          end else begin
            state_d = ST_IGNORE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; sr_q <= '0; rx_q <= '0; cnt_q <= '0;
      rose_q <= 1'b0; drv_q <= 1'b0; fa_q <= 1'b0; fd_q <= 1'b0;
      dir_q <= 1'b0; berr_q <= 1'b0; coll_q <= 1'b0;
    end else begin
      state_q <= state_d; sr_q <= sr_d; rx_q <= rx_d; cnt_q <= cnt_d;
      rose_q <= rose_d; drv_q <= drv_d; fa_q <= fa_d; fd_q <= fd_d;
      dir_q <= dir_d; berr_q <= berr_d; coll_q <= coll_d;
    end
  end

  assign sda_drv   = drv_q;
  assign rx_data   = rx_q;
  assign flag_addr = fa_q;
  assign flag_data = fd_q;
  assign dir_rd    = dir_q;
  assign bus_err   = berr_q;
  assign collision = coll_q;

  assert_ignore_is_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IGNORE) |-> !drv_q);
  assert_stop_releases_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !drv_q);
  assert_sda_moves_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drv_q) |-> !$past(scl_s));
  assert_collision_drops_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coll_q) |-> (!drv_q && state_q == ST_IGNORE));
  assert_bus_err_at_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(berr_q) |-> (state_q == ST_IDLE));
endmodule

// File: rtl/i2c_target_stretch.sv
module i2c_target_stretch #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [DATA_W-2:0] own_addr,
  input  logic              promisc_en,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              clr_addr,
  input  logic              clr_data,
  input  logic              clr_err,
  output logic [DATA_W-1:0] rx_data,
  output logic              flag_addr,
  output logic              flag_data,
  output logic              dir_rd,
  output logic              bus_err,
  output logic              collision,
  output logic              clk_hold
);
  logic [1:0] rst_pipe;
  logic       rst_int_n;
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det, sda_drv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  i2ct_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_int_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2ct_engine #(.DATA_W(DATA_W)) eng_i (
    .clk(clk), .rst_n(rst_int_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .own_addr(own_addr), .promisc_en(promisc_en),
    .tx_data(tx_data), .clr_addr(clr_addr), .clr_data(clr_data),
    .clr_err(clr_err), .sda_drv(sda_drv), .rx_data(rx_data),
    .flag_addr(flag_addr), .flag_data(flag_data), .dir_rd(dir_rd),
    .bus_err(bus_err), .collision(collision)
  );

  assign scl_oe   = flag_addr | flag_data;
  assign clk_hold = scl_oe;
  assign sda_oe   = sda_drv;

  assert_no_hold_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> (!scl_oe && !sda_oe));
endmodule

// File: tb/i2c_target_stretch_tb_top.sv
`timescale 1ns/1ps
module i2c_target_stretch_tb_top;
  localparam int Q = 8;
  localparam logic [6:0] OWN = 7'h3A;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, scl_m, sda_m, promisc_en, clr_addr, clr_data, clr_err;
  logic [6:0] own_addr;
  logic [7:0] tx_data, rx_data;
  logic scl_oe, sda_oe, flag_addr, flag_data, dir_rd, bus_err, collision, clk_hold;
  logic scl_line, sda_line;
  assign scl_line = scl_m & ~scl_oe;
  assign sda_line = sda_m & ~sda_oe;

  i2c_target_stretch dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own_addr), .promisc_en(promisc_en),
    .tx_data(tx_data), .clr_addr(clr_addr), .clr_data(clr_data), .clr_err(clr_err),
    .rx_data(rx_data), .flag_addr(flag_addr), .flag_data(flag_data), .dir_rd(dir_rd),
    .bus_err(bus_err), .collision(collision), .clk_hold(clk_hold)
  );

  int n_chk = 0, n_fail = 0;
  bit exp_rd, saw_addr;
  logic [7:0] tx_q [8];
  logic [7:0] rx_got [8];
  int tx_i, rx_i;

  task automatic chk_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_match(input logic [6:0] a, input bit rd, input bit pm);
    return pm || (a == OWN) || (a == 7'h00 && !rd);
  endfunction

  task automatic tick; @(negedge clk); endtask
  task automatic wq; repeat (Q) tick(); endtask

  // host side: answers flags while the bus clock is held
  task automatic service;
    if (flag_addr) begin
      chk_eq("R8 hold on addr flag", clk_hold, 1);
      chk_eq("R3 direction flag", dir_rd, exp_rd);
      saw_addr = 1'b1;
      clr_addr = 1'b1; tick(); clr_addr = 1'b0;
    end else if (flag_data) begin
      chk_eq("R8 hold on data flag", clk_hold, 1);
      if (dir_rd) begin
        tx_data = tx_q[tx_i]; tx_i++;
      end else begin
        rx_got[rx_i] = rx_data; rx_i++;
      end
      clr_data = 1'b1; tick(); clr_data = 1'b0;
    end else begin
      tick();
    end
  endtask

  task automatic raise;
    scl_m = 1'b1; tick();
    while (!scl_line) service();
  endtask

  task automatic bit_x(input bit b, output bit s);
    sda_m = b; wq(); raise(); wq(); s = sda_line; scl_m = 1'b0; wq();
  endtask

  task automatic start_c;
    sda_m = 1'b1; wq(); raise(); wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic stop_c;
    sda_m = 1'b0; wq(); raise(); wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) bit_x(v[i], s);
    bit_x(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] v);
    bit s;
    for (int i = 7; i >= 0; i--) begin bit_x(1'b1, s); v[i] = s; end
    bit_x(~mack, s);
  endtask

  task automatic xfer(input logic [6:0] a, input bit rd, input int n, input bit pm);
    bit ack, m;
    logic [7:0] v;
    logic [7:0] wb [8];
    string tag;
    m = exp_match(a, rd, pm);
    tag = !m ? "R4 mismatch ack" : (a == OWN) ? "R3 address ack" :
          pm ? "R5 promiscuous ack" : "R6 general call ack";
    promisc_en = pm; exp_rd = rd; saw_addr = 0; tx_i = 0; rx_i = 0;
    for (int k = 0; k < 8; k++) begin tx_q[k] = 8'($urandom); wb[k] = 8'($urandom); end
    start_c();
    send_byte({a, rd}, ack);
    chk_eq(tag, ack, m);
    if (m && rd) begin
      for (int k = 0; k < n; k++) begin
        recv_byte(k != n - 1, v);
        chk_eq(k == 0 ? "R10 read byte" : "R11 read after ack", v, tx_q[k]);
      end
      tick();
      chk_eq("R11 released after nack", sda_oe, 0);
      chk_eq("R11 no request after nack", flag_data, 0);
      stop_c();
    end else if (m) begin
      for (int k = 0; k < n; k++) begin
        send_byte(wb[k], ack);
        chk_eq("R9 write byte ack", ack, 1);
      end
      stop_c();
      chk_eq("R9 byte count", rx_i, n);
      for (int k = 0; k < n; k++) chk_eq("R9 received byte", rx_got[k], wb[k]);
    end else begin
      send_byte(wb[0], ack);
      chk_eq("R4 later byte ignored", ack, 0);
      chk_eq("R4 no flags", {flag_addr, flag_data}, 0);
      stop_c();
    end
    if (m) chk_eq("R3 address flag seen", saw_addr, 1);
    chk_eq("R8 hold released", clk_hold, 0);
    wq();
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    bit ack, s;
    logic [7:0] v;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; promisc_en = 1'b0;
    clr_addr = 1'b0; clr_data = 1'b0; clr_err = 1'b0; own_addr = OWN; tx_data = '0;
    repeat (4) tick();
    chk_eq("R1 outputs in reset", {scl_oe, sda_oe, flag_addr, flag_data, bus_err, collision}, 0);
    rst_n = 1'b1;
    repeat (6) tick();
    chk_eq("R1 state after reset", {scl_oe, sda_oe, flag_addr, flag_data, dir_rd, bus_err, collision}, 0);
    chk_eq("R1 rx after reset", rx_data, 0);

    // directed cases
    xfer(OWN, 1'b0, 2, 1'b0);
    xfer(OWN, 1'b1, 3, 1'b0);
    xfer(7'h00, 1'b0, 1, 1'b0);
    xfer(7'h11, 1'b0, 1, 1'b0);
    xfer(7'h11, 1'b1, 2, 1'b1);

    // START directly followed by STOP
    start_c(); stop_c(); wq();
    chk_eq("R7 bus error set", bus_err, 1);
    chk_eq("R7 no hold", clk_hold, 0);
    clr_err = 1'b1; tick(); clr_err = 1'b0; tick();
    chk_eq("R13 bus error cleared", bus_err, 0);

    // repeated START in the middle of a write byte
    exp_rd = 0; tx_i = 0; rx_i = 0; promisc_en = 0; tx_q[0] = 8'hC6;
    start_c();
    send_byte({OWN, 1'b0}, ack);
    chk_eq("R2 first address ack", ack, 1);
    bit_x(1'b1, s); bit_x(1'b0, s); bit_x(1'b1, s);
    exp_rd = 1;
    start_c();
    send_byte({OWN, 1'b1}, ack);
    chk_eq("R2 restart address ack", ack, 1);
    recv_byte(1'b0, v);
    chk_eq("R2 read after restart", v, 8'hC6);
    chk_eq("R2 partial byte discarded", rx_i, 0);
    stop_c(); wq();

    // collision while sending a 1 bit
    exp_rd = 1; tx_i = 0; tx_q[0] = 8'hFF;
    start_c();
    send_byte({OWN, 1'b1}, ack);
    chk_eq("R12 read address ack", ack, 1);
    sda_m = 1'b0; wq(); raise(); wq();
    chk_eq("R12 collision flag", collision, 1);
    chk_eq("R12 sda released", sda_oe, 0);
    scl_m = 1'b0; wq();
    bit_x(1'b1, s);
    chk_eq("R12 silent after collision", s, 1);
    stop_c(); wq();
    clr_err = 1'b1; tick(); clr_err = 1'b0; tick();
    chk_eq("R13 collision cleared", collision, 0);

    // constrained random transfers
    for (int t = 0; t < 24; t++) begin
      int kind;
      logic [6:0] a;
      kind = int'($urandom % 8);
      if (kind < 4)       a = OWN;
      else if (kind == 4) a = 7'h00;
      else                a = 7'(OWN + 7'(1 + $urandom % 100));
      xfer(a, bit'($urandom % 2), 1 + int'($urandom % 3), ($urandom % 4) == 0);
    end

    summary();
    $finish;
  end
endmodule